// File: doc/BRIEF.md
# Single-Bank Transpose Buffer Controller

This block sits between the two one-dimensional passes of an 8x8 separable transform. The first pass delivers one sample per valid cycle. The block stores each sample in a 64-word buffer. It also returns the sample that the second pass needs, which is the transposed element of the previous block. Only one bank is used. While a block is written, the word already held at each address belongs to the previous block, and that word is read out in the same cycle before it is overwritten.

The addressing alternates from block to block. The first block after reset goes row-major, the second column-major, the third row-major again, and so on. A sample with in-block index k has row r = k / 8 and column c = k % 8. Row-major places it at 8*r + c and column-major at 8*c + r. Reading the old word at the address the new sample is written to therefore yields the old block in transposed order. A three-state controller (idle, row, column) tracks the orientation and reports ready, full and task-finish status. The buffer address and the read and write strobes are brought out as ports.

Top module: `transpose_buffer_ctrl`

## Requirements
- R1: After reset, outValid, taskFinish, full and memRdEn are 0. The first block after reset is write-only: memRdEn and outValid stay 0 during all 64 of its samples.
- R2: For the k-th accepted sample of a block (k = 0..63, r = k/8, c = k%8), memAddr is 8*r + c in blocks with an even index counted from reset (0, 2, ...) and 8*c + r in blocks with an odd index.
- R3: memWrEn equals 1 in exactly the cycles where inValid is 1. In a cycle with inValid 0 there is no write, no read, and no change of memAddr, sample count or orientation.
- R4: From the second block onward, every accepted sample also asserts memRdEn at the same address. outValid is 1 in the cycle after a read and 0 after a cycle without a read.
- R5: The k-th output of block n+1 equals element 8*(k%8) + k/8 of input block n, so each output block is the exact transpose of the preceding input block.
- R6: taskFinish is a single-cycle pulse in the cycle after the 64th sample of a block is accepted.
- R7: full is 1 from the cycle after a block completes until the next accepted sample, and 0 during the first block.
- R8: ready is 0 during reset, becomes 1 on the first clock after reset and then stays 1.
- R9: Idle cycles inserted between samples change neither the output order nor the output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample from the first pass is valid this cycle |
| inData | input | DATA_W | Sample from the first pass |
| outValid | output | 1 | outData carries a transposed word this cycle |
| outData | output | DATA_W | Word read out for the second pass |
| memAddr | output | 2*log2(DIM) | Buffer address used this cycle |
| memWrEn | output | 1 | Buffer write strobe |
| memRdEn | output | 1 | Buffer read strobe |
| ready | output | 1 | Controller is out of reset and accepting samples |
| full | output | 1 | A complete block is stored and none of it has yet been replaced |
| taskFinish | output | 1 | One-cycle pulse after a block is complete |

## Verification
The bound checker checks the per-cycle rules on every cycle: reads happen only together with writes, outValid follows memRdEn by one cycle, an idle cycle freezes the address and moves no data, taskFinish is a one-cycle pulse that coincides with full, full drops on the next accepted sample, and ready holds once it is set. Only the bench scenarios can show the data-level behaviour. These are the exact address sequence in both orientations, the fact that every output block is the transpose of the block before it (including when idle gaps are inserted), and that the first block produces no output.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2
  } tbufState_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic colMajor;
  } tbufStrobes_t;
endpackage

// File: rtl/tbuf_ctrl.sv
module tbuf_ctrl #(
  parameter int DIM = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  output tbuf_pkg::tbufStrobes_t        strobes,
  output logic [2*$clog2(DIM)-1:0]      idx,
  output logic                          ready,
  output logic                          full,
  output logic                          taskFinish
);
  import tbuf_pkg::*;

  localparam int IDX_W = 2 * $clog2(DIM);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  tbufState_t state;
  logic [IDX_W-1:0] cnt;
  logic finishQ;
  logic readyQ;
  logic blockDone;

  assign blockDone = inValid && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      finishQ <= 1'b0;
      readyQ  <= 1'b0;
    end else begin
      readyQ  <= 1'b1;
      finishQ <= blockDone;
      if (inValid) begin
        cnt <= cnt + 1'b1;
      end
      if (blockDone) begin
        state <= (state == ST_COL) ? ST_ROW : ST_COL;
      end
    end
  end

  always_comb begin
    strobes.wrEn     = inValid;
    strobes.rdEn     = inValid && (state != ST_IDLE);
    strobes.colMajor = (state == ST_COL);
  end

  assign idx        = cnt;
  assign ready      = readyQ;
  assign taskFinish = finishQ;
  assign full       = (state != ST_IDLE) && (cnt == '0);
endmodule

// File: rtl/tbuf_addr_gen.sv
module tbuf_addr_gen #(
  parameter int DIM = 8
) (
  input  logic [2*$clog2(DIM)-1:0] idx,
  input  logic                     colMajor,
  output logic [2*$clog2(DIM)-1:0] addr
);
  localparam int HALF_W = $clog2(DIM);

  logic [HALF_W-1:0] rowPart;
  logic [HALF_W-1:0] colPart;

  assign rowPart = idx[2*HALF_W-1:HALF_W];
  assign colPart = idx[HALF_W-1:0];

  always_comb begin
    if (colMajor) addr = {colPart, rowPart};
    else          addr = {rowPart, colPart};
  end
endmodule

// File: rtl/tbuf_datapath.sv
module tbuf_datapath #(
  parameter int DATA_W = 16,
  parameter int DIM    = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tbuf_pkg::tbufStrobes_t    strobes,
  input  logic [2*$clog2(DIM)-1:0]  idx,
  input  logic [DATA_W-1:0]         inData,
  output logic [2*$clog2(DIM)-1:0]  memAddr,
  output logic                      outValid,
  output logic [DATA_W-1:0]         outData
);
  localparam int ADDR_W = 2 * $clog2(DIM);
  localparam int DEPTH  = DIM * DIM;

  logic [DATA_W-1:0] bufMem [DEPTH];
  logic [DATA_W-1:0] rdData;
  logic              rdValidQ;

  tbuf_addr_gen #(.DIM(DIM)) u_addr (
    .idx      (idx),
    .colMajor (strobes.colMajor),
    .addr     (memAddr)
  );

  // Read and write at one edge: the read samples the old word first.
  always_ff @(posedge clk) begin
    if (strobes.rdEn) rdData <= bufMem[memAddr];
    if (strobes.wrEn) bufMem[memAddr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= strobes.rdEn;
  end

  assign outValid = rdValidQ;
  assign outData  = rdData;

  logic unusedAddrW;
  assign unusedAddrW = ^ADDR_W;
endmodule

// File: rtl/transpose_buffer_ctrl.sv
module transpose_buffer_ctrl #(
  parameter int DATA_W = 16,
  parameter int DIM    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [DATA_W-1:0]        inData,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  output logic [2*$clog2(DIM)-1:0] memAddr,
  output logic                     memWrEn,
  output logic                     memRdEn,
  output logic                     ready,
  output logic                     full,
  output logic                     taskFinish
);
  localparam int IDX_W = 2 * $clog2(DIM);

  tbuf_pkg::tbufStrobes_t strobes;
  logic [IDX_W-1:0]       idx;

  tbuf_ctrl #(.DIM(DIM)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .strobes    (strobes),
    .idx        (idx),
    .ready      (ready),
    .full       (full),
    .taskFinish (taskFinish)
  );

  tbuf_datapath #(.DATA_W(DATA_W), .DIM(DIM)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .idx      (idx),
    .inData   (inData),
    .memAddr  (memAddr),
    .outValid (outValid),
    .outData  (outData)
  );

  assign memWrEn = strobes.wrEn;
  assign memRdEn = strobes.rdEn;
endmodule

// File: rtl/tbuf_checker.sv
module tbuf_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWrEn,
  input logic              memRdEn,
  input logic              ready,
  input logic              full,
  input logic              taskFinish
);
  p_read_needs_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> memWrEn);

  p_out_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> outValid);

  p_no_out_without_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memRdEn |=> !outValid);

  p_idle_no_access_r3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (!memWrEn && !memRdEn));

  p_idle_addr_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(memAddr));

  p_finish_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    taskFinish |=> !taskFinish);

  p_finish_means_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    taskFinish |-> full);

  p_full_clears_on_sample_r7: assert property (@(posedge clk) disable iff (!rstN)
    (full && inValid) |=> !full);

  p_ready_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);
endmodule

bind transpose_buffer_ctrl tbuf_checker #(.ADDR_W(2 * $clog2(DIM))) u_tbuf_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .outValid   (outValid),
  .memAddr    (memAddr),
  .memWrEn    (memWrEn),
  .memRdEn    (memRdEn),
  .ready      (ready),
  .full       (full),
  .taskFinish (taskFinish)
);

// File: tb/transpose_buffer_ctrl_test.sv
module transpose_buffer_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int DIM = 8;
  localparam int NWORDS = DIM * DIM;
  localparam int NBLK = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic outValid;
  logic [DATA_W-1:0] outData;
  logic [5:0] memAddr;
  logic memWrEn, memRdEn, ready, full, taskFinish;

  int nChecks = 0;
  int nFails = 0;
  int nOut = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  transpose_buffer_ctrl #(.DATA_W(DATA_W), .DIM(DIM)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData), .memAddr(memAddr),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .ready(ready),
    .full(full), .taskFinish(taskFinish)
  );

  function automatic logic [DATA_W-1:0] sampleVal(int b, int k);
    return DATA_W'((b + 1) * 256 + k * 3 + 7);
  endfunction

  task automatic check(string req, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Monitor: pops the scoreboard for every output word.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      nOut++;
      if (expQ.size() == 0) begin
        check("R1/R5 unexpected output", 1, 0);
      end else begin
        check("R5 transpose data", int'(outData), int'(expQ.pop_front()));
      end
    end
  end

  task automatic idleCycle();
    @(negedge clk);
    inValid = 1'b0;
    #1;
    check("R3 no write when idle", int'(memWrEn), 0);
    check("R3 no read when idle", int'(memRdEn), 0);
  endtask

  task automatic driveBlock(int b, int gapEvery);
    for (int k = 0; k < NWORDS; k++) begin
      int expAddr;
      if (gapEvery != 0 && (k % gapEvery) == gapEvery - 1) idleCycle();
      @(negedge clk);
      inValid = 1'b1;
      inData = sampleVal(b, k);
      #1;
      expAddr = (b % 2 == 0) ? k : 8 * (k % 8) + k / 8;
      check("R2 address", int'(memAddr), expAddr);
      check("R3 write strobe", int'(memWrEn), 1);
      if (b == 0) check("R1 first block write-only", int'(memRdEn), 0);
      else        check("R4 read strobe", int'(memRdEn), 1);
      if (b > 0) expQ.push_back(sampleVal(b - 1, 8 * (k % 8) + k / 8));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 taskFinish in reset", int'(taskFinish), 0);
    check("R1 full in reset", int'(full), 0);
    check("R8 ready low in reset", int'(ready), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", int'(ready), 1);
    check("R7 full low before any block", int'(full), 0);

    driveBlock(0, 0);
    idleCycle();
    check("R6 taskFinish pulse", int'(taskFinish), 1);
    check("R7 full after block", int'(full), 1);
    idleCycle();
    check("R6 taskFinish one cycle", int'(taskFinish), 0);
    check("R7 full holds while idle", int'(full), 1);
    check("R1 no output after write-only block", nOut, 0);

    driveBlock(1, 0);
    idleCycle();
    check("R6 taskFinish block 1", int'(taskFinish), 1);
    driveBlock(2, 5);   // R9: idle gaps inside the block
    driveBlock(3, 0);   // back to back with block 2
    check("R7 full low mid-block", int'(full), 0);
    driveBlock(4, 3);   // R9: dense gaps
    idleCycle();
    idleCycle();
    idleCycle();
    check("R5 all expected words seen", expQ.size(), 0);
    check("R9 output count", nOut, (NBLK - 1) * NWORDS);
    check("R8 ready still high", int'(ready), 1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule